// File: doc/BRIEF.md
# PWM Time Base with Double-Buffered Period

This block is the timing core of one PWM channel pair. An up-counter runs from zero to the active period, then returns to zero. It reports a counter-zero event and a period-match event. Two compare values are matched against the counter. A small action qualifier turns the zero, compare and period events into two raw PWM levels.

The period can be written in two ways, chosen by a per-instance mode input. In immediate mode a write goes straight into the active period. In shadowed mode the write waits in a shadow register until the counter is at zero. Both compare values are always shadowed and move to their active registers at counter zero. Several instances can be chained. A synchronization event (the chain input or a software strobe) loads a phase value into the counter when phase loading is enabled. The sync output either forwards the incoming sync or marks this instance's own counter-zero.

Because the shadow period transfers only at zero, a phase load that keeps lifting the counter past zero holds a pending period back for as long as that goes on. The block keeps this behaviour so that software can see and reason about it.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted, the counter, active period, shadow period, both compare registers and both PWM outputs are zero.
- R2: Without a sync load, a counter below the active period increments by one per clock. A counter at or above the active period becomes zero on the next clock.
- R3: With `prd_shadow_en`=1, a period write lands only in the shadow register. The active period takes the shadow value at each clock edge where the counter is zero. A write and a transfer in the same cycle move the old shadow value.
- R4: With `prd_shadow_en`=0, a period write appears in `prd_active` after the next clock edge, whatever the counter value.
- R5: When `phs_en`=1 and `sync_in` or `sw_sync` is high, the counter takes `phs_val` on the next edge. This load takes priority over increment and wrap. With `phs_en`=0 both sync inputs leave the counter unchanged in its path.
- R6: While sync loads keep the counter from reaching zero, a pending shadow period is not transferred, and `prd_active` keeps its old value.
- R7: `ctr_zero` is high exactly while the counter is 0. `ctr_prd` is high exactly while the counter equals `prd_active`.
- R8: With `sync_out_sel`=1, `sync_out` equals `ctr_zero`. With `sync_out_sel`=0, it equals `sync_in` OR `sw_sync`.
- R9: A compare write goes to that compare's shadow, and the active compare copies the shadow at each edge where the counter is zero.
- R10: Each PWM output is registered. It changes on the edge after an event is seen, as set by an 8-bit config: bits [1:0] zero, [3:2] compare A, [5:4] compare B, [7:6] period. Each code is 00 none, 01 clear, 10 set, 11 toggle. Among the events present, the one with a non-none code and the highest priority wins (period > compare B > compare A > zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prd_shadow_en | input | 1 | 1: shadowed period load, 0: immediate |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | CNT_W | Period write value |
| phs_en | input | 1 | Enables phase load on sync |
| phs_val | input | CNT_W | Phase value loaded into the counter |
| sync_in | input | 1 | Sync from the previous instance |
| sw_sync | input | 1 | Software force-sync strobe |
| sync_out_sel | input | 1 | 1: sync out at counter zero, 0: pass sync through |
| cmpa_wr | input | 1 | Compare A write strobe |
| cmpa_wdata | input | CNT_W | Compare A write value |
| cmpb_wr | input | 1 | Compare B write strobe |
| cmpb_wdata | input | CNT_W | Compare B write value |
| aq_cfg_a | input | 8 | Action config for output A |
| aq_cfg_b | input | 8 | Action config for output B |
| cnt | output | CNT_W | Counter value |
| prd_active | output | CNT_W | Active period |
| ctr_zero | output | 1 | Counter equals zero |
| ctr_prd | output | 1 | Counter equals active period |
| sync_out | output | 1 | Sync to the next instance |
| pwm_a | output | 1 | Raw PWM output A |
| pwm_b | output | 1 | Raw PWM output B |

## Verification
The hardest case is the stuck shadow period. A new period has to wait in the shadow while the counter keeps cycling without ever hitting zero. The stimulus gets there in three steps. It first runs until the counter sits a few counts above zero and writes the shadow. It then fires a sync every time the counter reaches a chosen value below the period, so each phase load sends the counter back up before it can wrap. After several such loops it stops the syncs, and the bench shows that the held period transfers at the first natural zero.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

  typedef enum logic [1:0] {
    AQ_NONE = 2'b00,
    AQ_CLR  = 2'b01,
    AQ_SET  = 2'b10,
    AQ_TGL  = 2'b11
  } aq_act_e;

  // Field order is behaviour: priority rises toward the MSB.
  typedef struct packed {
    aq_act_e on_prd;
    aq_act_e on_cmpb;
    aq_act_e on_cmpa;
    aq_act_e on_zero;
  } aq_cfg_t;

  localparam int AQ_CFG_W = $bits(aq_cfg_t);

  function automatic logic f_aq_apply(input aq_act_e act, input logic cur);
    case (act)
      AQ_CLR:  return 1'b0;
      AQ_SET:  return 1'b1;
      AQ_TGL:  return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwmtb_counter.sv
module pwmtb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prd_act,
  input  logic             phs_en,
  input  logic [CNT_W-1:0] phs_val,
  input  logic             sync_in,
  input  logic             sw_sync,
  output logic [CNT_W-1:0] cnt,
  output logic             at_zero,
  output logic             at_prd,
  output logic             sync_load
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  // Free-running step: wrap at or above the period, else count up.
  function automatic logic [CNT_W-1:0] f_step(input logic [CNT_W-1:0] c,
                                              input logic [CNT_W-1:0] p);
    if (c >= p) return ZERO;
    return c + ONE;
  endfunction

  assign sync_load = phs_en & (sync_in | sw_sync);
  assign at_zero   = (cnt == ZERO);
  assign at_prd    = (cnt == prd_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= ZERO;
    else if (sync_load) cnt <= phs_val;
    else                cnt <= f_step(cnt, prd_act);
  end

  p_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_load && cnt < prd_act) |=> cnt == $past(cnt) + ONE);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_load && cnt >= prd_act) |=> at_zero);

  p_phase_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_load |=> cnt == $past(phs_val));

  p_zero_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && prd_act != ZERO && !sync_load) |=> !at_zero);

endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shadow_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             at_zero,
  output logic [CNT_W-1:0] prd_act
);

  logic [CNT_W-1:0] prd_shd;
  logic             imm_load;
  logic             shd_xfer;

  assign imm_load = wr & ~shadow_en;
  assign shd_xfer = shadow_en & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_shd <= '0;
      prd_act <= '0;
    end else begin
      if (wr)            prd_shd <= wdata;
      if (imm_load)      prd_act <= wdata;
      else if (shd_xfer) prd_act <= prd_shd;
    end
  end

  p_prd_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !shadow_en) |=> prd_act == $past(wdata));

  p_prd_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && at_zero) |=> prd_act == $past(prd_shd));

  p_prd_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !at_zero) |=> $stable(prd_act));

endmodule

// File: rtl/pwmtb_cmp.sv
module pwmtb_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             xfer,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic [CNT_W-1:0] cmp_shd;
  logic [CNT_W-1:0] cmp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_shd <= '0;
      cmp_act <= '0;
    end else begin
      if (wr)   cmp_shd <= wdata;
      if (xfer) cmp_act <= cmp_shd;
    end
  end

  assign hit = (cnt == cmp_act);

  p_cmp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(cmp_act));

  p_cmp_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> cmp_act == $past(cmp_shd));

endmodule

// File: rtl/pwmtb_aq.sv
module pwmtb_aq
  import pwmtb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AQ_CFG_W-1:0] cfg_bits,
  input  logic                evt_zero,
  input  logic                evt_cmpa,
  input  logic                evt_cmpb,
  input  logic                evt_prd,
  output logic                pwm
);

  aq_cfg_t cfg;
  aq_act_e act;

  assign cfg = aq_cfg_t'(cfg_bits);

  always_comb begin
    if (evt_prd && cfg.on_prd != AQ_NONE)          act = cfg.on_prd;
    else if (evt_cmpb && cfg.on_cmpb != AQ_NONE)   act = cfg.on_cmpb;
    else if (evt_cmpa && cfg.on_cmpa != AQ_NONE)   act = cfg.on_cmpa;
    else if (evt_zero && cfg.on_zero != AQ_NONE)   act = cfg.on_zero;
    else                                           act = AQ_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= f_aq_apply(act, pwm);
  end

  p_aq_prd_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_prd && cfg.on_prd == AQ_SET) |=> pwm);

  p_aq_prd_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_prd && cfg.on_prd == AQ_CLR) |=> !pwm);

  p_aq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_prd && !evt_cmpb && !evt_cmpa && !evt_zero) |=> $stable(pwm));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prd_shadow_en,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_wdata,
  input  logic             phs_en,
  input  logic [CNT_W-1:0] phs_val,
  input  logic             sync_in,
  input  logic             sw_sync,
  input  logic             sync_out_sel,
  input  logic             cmpa_wr,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             cmpb_wr,
  input  logic [CNT_W-1:0] cmpb_wdata,
  input  logic [7:0]       aq_cfg_a,
  input  logic [7:0]       aq_cfg_b,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd_active,
  output logic             ctr_zero,
  output logic             ctr_prd,
  output logic             sync_out,
  output logic             pwm_a,
  output logic             pwm_b
);

  localparam int N_CMP = 2;
  localparam int N_OUT = 2;

  logic                       ev_zero;
  logic                       ev_prd;
  logic                       ev_sync_load;
  logic [N_CMP-1:0]           cmp_wr;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_wdata;
  logic [N_CMP-1:0]           cmp_hit;
  logic [N_OUT-1:0][AQ_CFG_W-1:0] out_cfg;
  logic [N_OUT-1:0]           out_pwm;

  pwmtb_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .prd_act   (prd_active),
    .phs_en    (phs_en),
    .phs_val   (phs_val),
    .sync_in   (sync_in),
    .sw_sync   (sw_sync),
    .cnt       (cnt),
    .at_zero   (ev_zero),
    .at_prd    (ev_prd),
    .sync_load (ev_sync_load)
  );

  pwmtb_period #(.CNT_W(CNT_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .shadow_en (prd_shadow_en),
    .wr        (prd_wr),
    .wdata     (prd_wdata),
    .at_zero   (ev_zero),
    .prd_act   (prd_active)
  );

  assign cmp_wr    = {cmpb_wr, cmpa_wr};
  assign cmp_wdata = {cmpb_wdata, cmpa_wdata};

  for (genvar gc = 0; gc < N_CMP; gc++) begin : g_cmp
    pwmtb_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cmp_wr[gc]),
      .wdata (cmp_wdata[gc]),
      .xfer  (ev_zero),
      .cnt   (cnt),
      .hit   (cmp_hit[gc])
    );
  end

  assign out_cfg = {aq_cfg_b, aq_cfg_a};

  for (genvar go = 0; go < N_OUT; go++) begin : g_aq
    pwmtb_aq u_aq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_bits (out_cfg[go]),
      .evt_zero (ev_zero),
      .evt_cmpa (cmp_hit[0]),
      .evt_cmpb (cmp_hit[1]),
      .evt_prd  (ev_prd),
      .pwm      (out_pwm[go])
    );
  end

  assign ctr_zero = ev_zero;
  assign ctr_prd  = ev_prd;
  assign sync_out = sync_out_sel ? ev_zero : (sync_in | sw_sync);
  assign pwm_a    = out_pwm[0];
  assign pwm_b    = out_pwm[1];

  p_no_load_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!phs_en && cnt < prd_active) |=> cnt == $past(cnt) + CNT_W'(1));

  p_prd_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_prd && !ev_sync_load) |=> ctr_zero);

endmodule

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         prd_shadow_en = 1'b0, prd_wr = 1'b0;
  logic [W-1:0] prd_wdata = '0;
  logic         phs_en = 1'b0;
  logic [W-1:0] phs_val = '0;
  logic         sync_in = 1'b0, sw_sync = 1'b0, sync_out_sel = 1'b0;
  logic         cmpa_wr = 1'b0, cmpb_wr = 1'b0;
  logic [W-1:0] cmpa_wdata = '0, cmpb_wdata = '0;
  logic [7:0]   aq_cfg_a = '0, aq_cfg_b = '0;
  logic [W-1:0] cnt, prd_active;
  logic         ctr_zero, ctr_prd, sync_out, pwm_a, pwm_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side model state
  logic [W-1:0] m_cnt = '0, m_prd = '0, m_shd = '0;
  logic [W-1:0] m_ca = '0, m_cas = '0, m_cb = '0, m_cbs = '0;
  logic         m_pa = 1'b0, m_pb = 1'b0;

  typedef struct packed {
    logic [W-1:0] cnt;
    logic [W-1:0] prd;
    logic         z;
    logic         p;
    logic         so;
    logic         pa;
    logic         pb;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pwm_timebase #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .prd_shadow_en(prd_shadow_en), .prd_wr(prd_wr),
    .prd_wdata(prd_wdata), .phs_en(phs_en), .phs_val(phs_val), .sync_in(sync_in),
    .sw_sync(sw_sync), .sync_out_sel(sync_out_sel), .cmpa_wr(cmpa_wr),
    .cmpa_wdata(cmpa_wdata), .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
    .aq_cfg_a(aq_cfg_a), .aq_cfg_b(aq_cfg_b), .cnt(cnt), .prd_active(prd_active),
    .ctr_zero(ctr_zero), .ctr_prd(ctr_prd), .sync_out(sync_out),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, expv, $time);
    end
  endtask

  // Action qualifier model: later lines override earlier ones (rising priority).
  function automatic logic aq_model(input logic cur, input logic [7:0] cfg,
                                    input logic z, input logic ca,
                                    input logic cb, input logic pr);
    logic [1:0] a = 2'b00;
    if (z  && cfg[1:0] != 2'b00) a = cfg[1:0];
    if (ca && cfg[3:2] != 2'b00) a = cfg[3:2];
    if (cb && cfg[5:4] != 2'b00) a = cfg[5:4];
    if (pr && cfg[7:6] != 2'b00) a = cfg[7:6];
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  // Driver: predict the state after the coming edge, queue it, advance.
  task automatic tick(input string tag);
    exp_t e;
    logic z, pr, ca, cb;
    logic [W-1:0] n_cnt, n_prd, n_shd;
    z  = (m_cnt == 0);
    pr = (m_cnt == m_prd);
    ca = (m_cnt == m_ca);
    cb = (m_cnt == m_cb);
    if (phs_en && (sync_in || sw_sync)) n_cnt = phs_val;
    else if (m_cnt < m_prd)             n_cnt = m_cnt + 1'b1;
    else                                n_cnt = '0;
    n_shd = prd_wr ? prd_wdata : m_shd;
    if (prd_wr && !prd_shadow_en)       n_prd = prd_wdata;
    else if (prd_shadow_en && z)        n_prd = m_shd;
    else                                n_prd = m_prd;
    m_pa  = aq_model(m_pa, aq_cfg_a, z, ca, cb, pr);
    m_pb  = aq_model(m_pb, aq_cfg_b, z, ca, cb, pr);
    if (z) begin m_ca = m_cas; m_cb = m_cbs; end
    if (cmpa_wr) m_cas = cmpa_wdata;
    if (cmpb_wr) m_cbs = cmpb_wdata;
    m_cnt = n_cnt; m_prd = n_prd; m_shd = n_shd;
    e.cnt = m_cnt;
    e.prd = m_prd;
    e.z   = (m_cnt == 0);
    e.p   = (m_cnt == m_prd);
    e.so  = sync_out_sel ? (m_cnt == 0) : (sync_in | sw_sync);
    e.pa  = m_pa;
    e.pb  = m_pb;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk); #1;
  endtask

  // Monitor: compare queued predictions away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "cnt",        32'(cnt),        32'(e.cnt));
      chk(t, "prd_active", 32'(prd_active), 32'(e.prd));
      chk(t, "ctr_zero",   32'(ctr_zero),   32'(e.z));
      chk(t, "ctr_prd",    32'(ctr_prd),    32'(e.p));
      chk(t, "sync_out",   32'(sync_out),   32'(e.so));
      chk(t, "pwm_a",      32'(pwm_a),      32'(e.pa));
      chk(t, "pwm_b",      32'(pwm_b),      32'(e.pb));
    end
  end

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic write_prd(input logic [W-1:0] v, input string tag);
    prd_wr = 1'b1; prd_wdata = v; tick(tag); prd_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed while reset is held
    chk("R1", "cnt",        32'(cnt), 0);
    chk("R1", "prd_active", 32'(prd_active), 0);
    chk("R1", "pwm_a",      32'(pwm_a), 0);
    chk("R1", "pwm_b",      32'(pwm_b), 0);
    chk("R1", "ctr_zero",   32'(ctr_zero), 1);
    #1 rst_n = 1'b1;

    // R4 immediate period, R9 compare shadows, R10 priority (compare A at 0)
    aq_cfg_a = 8'h06;  // zero: set, cmpa: clear
    aq_cfg_b = 8'h48;  // cmpa: set, prd: clear
    write_prd(16'd9, "R4");
    run(3, "R10");
    cmpa_wr = 1'b1; cmpa_wdata = 16'd4; cmpb_wr = 1'b1; cmpb_wdata = 16'd6;
    tick("R9"); cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    run(25, "R2/R7/R9/R10");

    // R10 toggle on compare B for output A
    aq_cfg_a = 8'h36;
    run(22, "R10");
    aq_cfg_a = 8'h06;

    // R3 shadowed period: write mid-cycle, transfer at zero
    prd_shadow_en = 1'b1;
    while (m_cnt != 3) tick("R2");
    write_prd(16'd6, "R3");
    run(20, "R3");
    // write landing in a zero cycle moves the old shadow
    while (m_cnt != 0) tick("R2");
    write_prd(16'd8, "R3");
    run(20, "R3");

    // R5 phase loads: sync_in, sw_sync, and ignored with phs_en low
    phs_val = 16'd5;
    while (m_cnt != 2) tick("R2");
    sync_in = 1'b1; tick("R5"); sync_in = 1'b0;   // sync_in ignored
    phs_en = 1'b1;
    sync_in = 1'b1; tick("R5"); sync_in = 1'b0;
    run(3, "R5");
    sw_sync = 1'b1; tick("R5"); sw_sync = 1'b0;
    while (m_cnt != 8) tick("R2");
    sync_in = 1'b1; tick("R5"); sync_in = 1'b0;   // load beats wrap
    run(6, "R5");

    // R8 sync out in both selections
    sync_out_sel = 1'b0;
    sync_in = 1'b1; tick("R8"); sync_in = 1'b0;
    phs_en = 1'b0;
    sw_sync = 1'b1; tick("R8"); sw_sync = 1'b0;
    run(3, "R8");
    sync_out_sel = 1'b1;
    run(12, "R8");

    // R6 pending shadow period held back by repeated phase loads
    phs_en = 1'b1; phs_val = 16'd2;
    while (m_cnt != 2) tick("R2");
    write_prd(16'd4, "R6");
    for (int i = 0; i < 16; i++) begin
      sync_in = (m_cnt == 5);
      tick("R6");
      sync_in = 1'b0;
    end
    chk("R6", "prd_active held", 32'(prd_active), 8);
    run(16, "R6");           // syncs stop: wraps, zero transfers 4

    // R4/R2 immediate shrink below the running counter
    prd_shadow_en = 1'b0;
    write_prd(16'd12, "R4");
    while (m_cnt != 10) tick("R2");
    write_prd(16'd3, "R4");
    run(10, "R2");

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule